// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block drives the timing side of a parallel TFT panel. It takes a reference clock, divides it down to a pixel clock, and walks a horizontal and a vertical position counter through the four phases of every line and every frame. From these counters it produces horizontal sync, vertical sync, data-enable, a pixel-rate strobe for downstream pixel logic, and one-cycle start-of-frame and end-of-frame markers. The pixel and line counters are also brought out.

The geometry comes from static configuration inputs in compact register form. Several lengths are stored as the count minus one, some are stored as the plain count, the active width is stored in units of 16 pixels, and the wider fields are split into low and high parts. The block puts each length back together before use. Per-signal inversion bits set the idle level of each sync pin and of the pixel clock. An optional mode moves the sync pins so that they change on the rising pixel-clock edge instead of with the counters.

Top module: `panel_scan_gen`

## Requirements
- R1: The pixel period is D reference cycles. The pixel-clock level is low for the first floor(D/2) cycles of each pixel and high for the rest. `pix_ce_o` is high in the first cycle of every pixel and in no other cycle.
- R2: A divisor field of 0 or 1 behaves exactly as a divisor of 2. Values from 2 to 255 are used as given.
- R3: The horizontal lengths are decoded as follows. Sync length = {hsync_hi(4b), hsync_lo(6b)} + 1. Back porch = {hback_hi(2b), hback_lo(8b)} + 1. Front porch = {hfront_hi(2b), hfront_lo(8b)} + 1. Active width = ({width_hi(1b), width_lo(6b)} + 1) × 16.
- R4: The vertical lengths are decoded as follows. Sync length = vsync field + 1. Back porch and front porch are the field values unchanged, and zero is allowed. Active lines = {lines_hi(1b), lines_lo(10b)} + 1.
- R5: Each line runs sync, back porch, active, front porch, and each frame runs the same four phases in lines. `px_cnt_o` counts 0 up to the line total minus 1, advancing once per pixel. `ln_cnt_o` advances when the pixel counter wraps, and both wrap to 0 at the end of the frame.
- R6: `de_o` is high exactly when both the pixel counter and the line counter are in their active phase.
- R7: With an inversion bit clear, the matching sync pin or pixel-clock pin is active high and idles low. With the bit set, that pin is inverted and idles high.
- R8: When edge launch is on and the rising edge is chosen, hsync and vsync change in the cycle the pixel-clock level rises, and they carry the value for the current pixel. Before the first rising edge after a start they are inactive. With any other setting of the two bits, the sync pins change in the same cycle as the counters.
- R9: `sof_o` is a one-cycle pulse in the first cycle of each frame, including the first frame after enabling. At that cycle both counters are 0.
- R10: `eof_o` is a one-cycle pulse in the cycle in which `de_o` falls after the last active pixel of the last active line.
- R11: While `enable_i` is low, both counters are 0, `de_o`, `pix_ce_o`, `sof_o` and `eof_o` are low, and the sync and clock pins sit at their idle levels. Dropping enable takes priority over a pixel advance due in the same cycle. Raising enable restarts at pixel 0 of line 0.
- R12: The asynchronous active-low reset puts the block into the same state as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low clears and idles the block |
| div_i | input | 8 | Reference-to-pixel clock divisor |
| hsync_lo_i | input | 6 | Horizontal sync length minus one, low part |
| hsync_hi_i | input | 4 | Horizontal sync length minus one, high part |
| hback_lo_i | input | 8 | Horizontal back porch minus one, low part |
| hback_hi_i | input | 2 | Horizontal back porch minus one, high part |
| hfront_lo_i | input | 8 | Horizontal front porch minus one, low part |
| hfront_hi_i | input | 2 | Horizontal front porch minus one, high part |
| width_lo_i | input | 6 | (Active width − 1) bits 9:4 |
| width_hi_i | input | 1 | (Active width − 1) bit 10 |
| vsync_i | input | 6 | Vertical sync length minus one |
| vback_i | input | 8 | Vertical back porch in lines |
| vfront_i | input | 8 | Vertical front porch in lines |
| lines_lo_i | input | 10 | (Active lines − 1) bits 9:0 |
| lines_hi_i | input | 1 | (Active lines − 1) bit 10 |
| inv_hsync_i | input | 1 | Invert hsync pin |
| inv_vsync_i | input | 1 | Invert vsync pin |
| inv_pclk_i | input | 1 | Invert pixel-clock pin |
| edge_sync_en_i | input | 1 | Launch syncs on a chosen pixel-clock edge |
| edge_rise_i | input | 1 | Chosen edge is rising when set |
| pclk_o | output | 1 | Pixel clock pin |
| pix_ce_o | output | 1 | One-cycle strobe at the start of each pixel |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data enable |
| px_cnt_o | output | 13 | Pixel position in the line |
| ln_cnt_o | output | 12 | Line position in the frame |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
The case that needs the most care is a drop of enable in the very cycle where the divider reaches its terminal count. In that cycle a counter advance and the clear both want the same registers. The bench runs the block until the sample shows the last cycle of a pixel in the middle of a line, lowers enable at that point, and then expects the next sample to show zero counters and idle pins, not the next pixel. A second pairing comes at the end of every frame: the pixel wrap, the line wrap and the start-of-frame marker all occur on one tick. Every run therefore spans at least one full frame boundary, and each cycle is compared against a model built from the requirement formulas.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;
  // configuration field widths
  parameter int DIV_W     = 8;
  parameter int HP_LO_W   = 8;
  parameter int HP_HI_W   = 2;
  parameter int HS_LO_W   = 6;
  parameter int HS_HI_W   = 4;
  parameter int WID_W     = 7;
  parameter int WID_SHIFT = 4;
  parameter int VP_W      = 8;
  parameter int VS_W      = 6;
  parameter int LN_W      = 11;

  localparam int HP_W  = HP_LO_W + HP_HI_W;
  localparam int HS_W  = HS_LO_W + HS_HI_W;
  localparam int H_MAX = (1 << HS_W) + 2 * (1 << HP_W) + ((1 << WID_W) << WID_SHIFT);
  localparam int V_MAX = (1 << VS_W) + 2 * ((1 << VP_W) - 1) + (1 << LN_W);
  localparam int H_CNT_W = $clog2(H_MAX + 1);
  localparam int V_CNT_W = $clog2(V_MAX + 1);

  typedef struct packed {
    logic [H_CNT_W-1:0] sync_len;
    logic [H_CNT_W-1:0] back_len;
    logic [H_CNT_W-1:0] act_len;
    logic [H_CNT_W-1:0] front_len;
  } h_geom_t;

  typedef struct packed {
    logic [V_CNT_W-1:0] sync_len;
    logic [V_CNT_W-1:0] back_len;
    logic [V_CNT_W-1:0] act_len;
    logic [V_CNT_W-1:0] front_len;
  } v_geom_t;
endpackage

// File: rtl/scan_field_decode.sv
module scan_field_decode
  import panel_scan_pkg::*;
(
  input  logic [DIV_W-1:0]   div_i,
  input  logic [HS_LO_W-1:0] hsync_lo_i,
  input  logic [HS_HI_W-1:0] hsync_hi_i,
  input  logic [HP_LO_W-1:0] hback_lo_i,
  input  logic [HP_HI_W-1:0] hback_hi_i,
  input  logic [HP_LO_W-1:0] hfront_lo_i,
  input  logic [HP_HI_W-1:0] hfront_hi_i,
  input  logic [WID_W-2:0]   width_lo_i,
  input  logic               width_hi_i,
  input  logic [VS_W-1:0]    vsync_i,
  input  logic [VP_W-1:0]    vback_i,
  input  logic [VP_W-1:0]    vfront_i,
  input  logic [LN_W-2:0]    lines_lo_i,
  input  logic               lines_hi_i,
  output logic [DIV_W-1:0]   div_eff_o,
  output h_geom_t            h_geom_o,
  output v_geom_t            v_geom_o
);
  localparam logic [H_CNT_W-1:0] H_ONE   = {{(H_CNT_W-1){1'b0}}, 1'b1};
  localparam logic [V_CNT_W-1:0] V_ONE   = {{(V_CNT_W-1){1'b0}}, 1'b1};
  localparam logic [DIV_W-1:0]   DIV_MIN = {{(DIV_W-2){1'b0}}, 2'b10};

  always_comb begin
    // divisors below the legal minimum are treated as the minimum
    div_eff_o = (div_i < DIV_MIN) ? DIV_MIN : div_i;
    // horizontal: every length stored minus one, wide ones split in two parts
    h_geom_o.sync_len  = {{(H_CNT_W-HS_W){1'b0}}, hsync_hi_i, hsync_lo_i} + H_ONE;
    h_geom_o.back_len  = {{(H_CNT_W-HP_W){1'b0}}, hback_hi_i, hback_lo_i} + H_ONE;
    h_geom_o.front_len = {{(H_CNT_W-HP_W){1'b0}}, hfront_hi_i, hfront_lo_i} + H_ONE;
    h_geom_o.act_len   = ({{(H_CNT_W-WID_W){1'b0}}, width_hi_i, width_lo_i} + H_ONE)
                         << WID_SHIFT;
    // vertical: porches stored as plain counts, sync and lines minus one
    v_geom_o.sync_len  = {{(V_CNT_W-VS_W){1'b0}}, vsync_i} + V_ONE;
    v_geom_o.back_len  = {{(V_CNT_W-VP_W){1'b0}}, vback_i};
    v_geom_o.front_len = {{(V_CNT_W-VP_W){1'b0}}, vfront_i};
    v_geom_o.act_len   = {{(V_CNT_W-LN_W){1'b0}}, lines_hi_i, lines_lo_i} + V_ONE;
  end
endmodule

// File: rtl/scan_pclk_div.sv
module scan_pclk_div
  import panel_scan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             rise_o,
  output logic             pclk_lvl_o
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q, cnt_d, half;
  logic             lvl_q, lvl_d, run;

  always_comb begin
    half   = div_i >> 1;
    run    = !clear_i && !start_i;
    tick_o = run && (cnt_q == div_i - ONE);
    rise_o = run && (cnt_q == half - ONE);
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    if (!run) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (tick_o) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else begin
      cnt_d = cnt_q + ONE;
      if (rise_o) lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign pclk_lvl_o = lvl_q;
endmodule

// File: rtl/scan_axis_counter.sv
module scan_axis_counter #(
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [CW-1:0] sync_len_i,
  input  logic [CW-1:0] back_len_i,
  input  logic [CW-1:0] act_len_i,
  input  logic [CW-1:0] front_len_i,
  output logic [CW-1:0] pos_o,
  output logic          last_o,
  output logic          act_last_o,
  output logic          in_sync_o,
  output logic          in_act_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] pos_q, pos_d, act_beg, act_end, total;
  logic          sync_q, sync_d, act_q, act_d;

  always_comb begin
    act_beg    = sync_len_i + back_len_i;
    act_end    = act_beg + act_len_i;
    total      = act_end + front_len_i;
    last_o     = (pos_q == total - ONE);
    act_last_o = (pos_q == act_end - ONE);
    pos_d  = pos_q;
    sync_d = sync_q;
    act_d  = act_q;
    if (clear_i) begin
      pos_d  = '0;
      sync_d = 1'b0;
      act_d  = 1'b0;
    end else if (start_i || step_i) begin
      pos_d  = (start_i || last_o) ? '0 : pos_q + ONE;
      // phase flags follow the new position: sync, back, active, front
      sync_d = (pos_d < sync_len_i);
      act_d  = (pos_d >= act_beg) && (pos_d < act_end);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      sync_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sync_q <= sync_d;
      act_q  <= act_d;
    end
  end

  assign pos_o     = pos_q;
  assign in_sync_o = sync_q;
  assign in_act_o  = act_q;
endmodule

// File: rtl/panel_scan_gen.sv
module panel_scan_gen
  import panel_scan_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [HS_LO_W-1:0] hsync_lo_i,
  input  logic [HS_HI_W-1:0] hsync_hi_i,
  input  logic [HP_LO_W-1:0] hback_lo_i,
  input  logic [HP_HI_W-1:0] hback_hi_i,
  input  logic [HP_LO_W-1:0] hfront_lo_i,
  input  logic [HP_HI_W-1:0] hfront_hi_i,
  input  logic [WID_W-2:0]   width_lo_i,
  input  logic               width_hi_i,
  input  logic [VS_W-1:0]    vsync_i,
  input  logic [VP_W-1:0]    vback_i,
  input  logic [VP_W-1:0]    vfront_i,
  input  logic [LN_W-2:0]    lines_lo_i,
  input  logic               lines_hi_i,
  input  logic               inv_hsync_i,
  input  logic               inv_vsync_i,
  input  logic               inv_pclk_i,
  input  logic               edge_sync_en_i,
  input  logic               edge_rise_i,
  output logic               pclk_o,
  output logic               pix_ce_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [H_CNT_W-1:0] px_cnt_o,
  output logic [V_CNT_W-1:0] ln_cnt_o,
  output logic               sof_o,
  output logic               eof_o
);
  logic [DIV_W-1:0] div_eff;
  h_geom_t          h_geom;
  v_geom_t          v_geom;
  logic clear, start, tick, rise_ev, pclk_lvl, line_wrap, rise_mode;
  logic h_last, h_act_last, h_sync, h_act;
  logic v_last, v_act_last, v_sync, v_act;
  logic run_q, ce_q, sof_q, eof_q, hs_pin_q, vs_pin_q;
  logic run_d, ce_d, sof_d, eof_d, hs_pin_d, vs_pin_d;

  scan_field_decode u_dec (
    .div_i, .hsync_lo_i, .hsync_hi_i, .hback_lo_i, .hback_hi_i,
    .hfront_lo_i, .hfront_hi_i, .width_lo_i, .width_hi_i,
    .vsync_i, .vback_i, .vfront_i, .lines_lo_i, .lines_hi_i,
    .div_eff_o(div_eff), .h_geom_o(h_geom), .v_geom_o(v_geom)
  );

  assign clear     = !enable_i;
  assign start     = enable_i && !run_q;
  assign line_wrap = tick && h_last;
  assign rise_mode = edge_sync_en_i && edge_rise_i;

  scan_pclk_div u_div (
    .clk_i, .rst_ni, .clear_i(clear), .start_i(start), .div_i(div_eff),
    .tick_o(tick), .rise_o(rise_ev), .pclk_lvl_o(pclk_lvl)
  );

  scan_axis_counter #(.CW(H_CNT_W)) u_hax (
    .clk_i, .rst_ni, .clear_i(clear), .start_i(start), .step_i(tick),
    .sync_len_i(h_geom.sync_len), .back_len_i(h_geom.back_len),
    .act_len_i(h_geom.act_len), .front_len_i(h_geom.front_len),
    .pos_o(px_cnt_o), .last_o(h_last), .act_last_o(h_act_last),
    .in_sync_o(h_sync), .in_act_o(h_act)
  );

  scan_axis_counter #(.CW(V_CNT_W)) u_vax (
    .clk_i, .rst_ni, .clear_i(clear), .start_i(start), .step_i(line_wrap),
    .sync_len_i(v_geom.sync_len), .back_len_i(v_geom.back_len),
    .act_len_i(v_geom.act_len), .front_len_i(v_geom.front_len),
    .pos_o(ln_cnt_o), .last_o(v_last), .act_last_o(v_act_last),
    .in_sync_o(v_sync), .in_act_o(v_act)
  );

  always_comb begin
    run_d = enable_i;
    ce_d  = start || tick;
    sof_d = start || (line_wrap && v_last);
    eof_d = tick && h_act_last && v_act_last;
    hs_pin_d = hs_pin_q;
    vs_pin_d = vs_pin_q;
    if (clear || start) begin
      hs_pin_d = 1'b0;
      vs_pin_d = 1'b0;
    end else if (rise_ev) begin
      hs_pin_d = h_sync;
      vs_pin_d = v_sync;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ce_q     <= 1'b0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      hs_pin_q <= 1'b0;
      vs_pin_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      ce_q     <= ce_d;
      sof_q    <= sof_d;
      eof_q    <= eof_d;
      hs_pin_q <= hs_pin_d;
      vs_pin_q <= vs_pin_d;
    end
  end

  assign pclk_o   = pclk_lvl ^ inv_pclk_i;
  assign hsync_o  = (rise_mode ? hs_pin_q : h_sync) ^ inv_hsync_i;
  assign vsync_o  = (rise_mode ? vs_pin_q : v_sync) ^ inv_vsync_i;
  assign de_o     = h_act && v_act;
  assign pix_ce_o = ce_q;
  assign sof_o    = sof_q;
  assign eof_o    = eof_q;
endmodule

// File: rtl/panel_scan_checker.sv
module panel_scan_checker
  import panel_scan_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               inv_pclk_i,
  input logic               pclk_o,
  input logic               pix_ce_o,
  input logic               de_o,
  input logic [H_CNT_W-1:0] px_cnt_o,
  input logic [V_CNT_W-1:0] ln_cnt_o,
  input logic               sof_o,
  input logic               eof_o
);
  assert_ce_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ce_o |=> !pix_ce_o);

  assert_cnt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && $past(enable_i) && !pix_ce_o) |-> $stable(px_cnt_o));

  assert_pclk_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pclk_o == inv_pclk_i));

  assert_sof_origin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (px_cnt_o == '0 && ln_cnt_o == '0));

  assert_sof_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  assert_eof_de_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> (!de_o && $past(de_o)));

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (px_cnt_o == '0 && ln_cnt_o == '0 && !de_o && !sof_o
                   && !eof_o && !pix_ce_o));
endmodule

bind panel_scan_gen panel_scan_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .inv_pclk_i(inv_pclk_i),
  .pclk_o(pclk_o), .pix_ce_o(pix_ce_o), .de_o(de_o), .px_cnt_o(px_cnt_o),
  .ln_cnt_o(ln_cnt_o), .sof_o(sof_o), .eof_o(eof_o)
);

// File: tb/sim_panel_scan_gen.sv
`timescale 1ns/1ps
module sim_panel_scan_gen;
  import panel_scan_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic [7:0] div;
  logic [5:0] hs_lo; logic [3:0] hs_hi;
  logic [7:0] hb_lo; logic [1:0] hb_hi;
  logic [7:0] hf_lo; logic [1:0] hf_hi;
  logic [5:0] w_lo;  logic w_hi;
  logic [5:0] vs_f;  logic [7:0] vb_f; logic [7:0] vf_f;
  logic [9:0] ln_lo; logic ln_hi;
  logic inv_hs, inv_vs, inv_pc, edge_en, edge_rise;

  logic pclk, ce, hsync, vsync, de, sof, eof;
  logic [H_CNT_W-1:0] px;
  logic [V_CNT_W-1:0] ln;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int d_eff, hsl, hbl, hal, hfl, ht, vsl, vbl, val, vfl, vt;

  always #2 clk = ~clk;

  panel_scan_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .div_i(div),
    .hsync_lo_i(hs_lo), .hsync_hi_i(hs_hi), .hback_lo_i(hb_lo), .hback_hi_i(hb_hi),
    .hfront_lo_i(hf_lo), .hfront_hi_i(hf_hi), .width_lo_i(w_lo), .width_hi_i(w_hi),
    .vsync_i(vs_f), .vback_i(vb_f), .vfront_i(vf_f), .lines_lo_i(ln_lo), .lines_hi_i(ln_hi),
    .inv_hsync_i(inv_hs), .inv_vsync_i(inv_vs), .inv_pclk_i(inv_pc),
    .edge_sync_en_i(edge_en), .edge_rise_i(edge_rise),
    .pclk_o(pclk), .pix_ce_o(ce), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .px_cnt_o(px), .ln_cnt_o(ln), .sof_o(sof), .eof_o(eof)
  );

  task automatic chk(string scen, string sig, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", scen, sig, act, exp);
    end
  endtask

  // lengths from the R2/R3/R4 formulas
  task automatic decode_cfg();
    d_eff = (div < 2) ? 2 : int'(div);
    hsl = int'({hs_hi, hs_lo}) + 1;
    hbl = int'({hb_hi, hb_lo}) + 1;
    hfl = int'({hf_hi, hf_lo}) + 1;
    hal = (int'({w_hi, w_lo}) + 1) * 16;
    vsl = int'(vs_f) + 1;
    vbl = int'(vb_f);
    vfl = int'(vf_f);
    val = int'({ln_hi, ln_lo}) + 1;
    ht = hsl + hbl + hal + hfl;
    vt = vsl + vbl + val + vfl;
  endtask

  task automatic set_geom(int dv, int hs, int hb, int wf, int hf, int vs, int vb,
                          int lnf, int vf);
    div = 8'(dv);
    {hs_hi, hs_lo} = 10'(hs); {hb_hi, hb_lo} = 10'(hb);
    {hf_hi, hf_lo} = 10'(hf); {w_hi, w_lo} = 7'(wf);
    vs_f = 6'(vs); vb_f = 8'(vb); vf_f = 8'(vf); {ln_hi, ln_lo} = 11'(lnf);
  endtask

  task automatic check_idle(string scen);
    chk(scen, "pclk idle R11", int'(pclk), int'(inv_pc));
    chk(scen, "hsync idle R11", int'(hsync), int'(inv_hs));
    chk(scen, "vsync idle R11", int'(vsync), int'(inv_vs));
    chk(scen, "de idle R11", int'(de), 0);
    chk(scen, "ce idle R11", int'(ce), 0);
    chk(scen, "sof idle R11", int'(sof), 0);
    chk(scen, "eof idle R11", int'(eof), 0);
    chk(scen, "px idle R11", int'(px), 0);
    chk(scen, "ln idle R11", int'(ln), 0);
  endtask

  // expected outputs k cycles after the enabling edge
  task automatic check_cycle(string scen, int k);
    int p = k / d_eff;
    int ph = k % d_eff;
    int fl = ht * vt;
    int f = p % fl;
    int h = f % ht;
    int v = f / ht;
    int q = (p + fl - 1) % fl;
    int qh = q % ht;
    int qv = q / ht;
    int hs_e = (h < hsl) ? 1 : 0;
    int vs_e = (v < vsl) ? 1 : 0;
    int de_e, eof_e;
    if (edge_en && edge_rise && ph < d_eff / 2) begin
      hs_e = (p == 0) ? 0 : ((qh < hsl) ? 1 : 0);
      vs_e = (p == 0) ? 0 : ((qv < vsl) ? 1 : 0);
    end
    de_e = (h >= hsl + hbl && h < hsl + hbl + hal &&
            v >= vsl + vbl && v < vsl + vbl + val) ? 1 : 0;
    eof_e = (ph == 0 && p > 0 && qh == hsl + hbl + hal - 1 &&
             qv == vsl + vbl + val - 1) ? 1 : 0;
    chk(scen, "pclk R1", int'(pclk), ((ph >= d_eff / 2) ? 1 : 0) ^ int'(inv_pc));
    chk(scen, "pix_ce R1", int'(ce), (ph == 0) ? 1 : 0);
    chk(scen, "px_cnt R5", int'(px), h);
    chk(scen, "ln_cnt R5", int'(ln), v);
    chk(scen, "de R6", int'(de), de_e);
    chk(scen, "hsync R7/R8", int'(hsync), hs_e ^ int'(inv_hs));
    chk(scen, "vsync R7/R8", int'(vsync), vs_e ^ int'(inv_vs));
    chk(scen, "sof R9", int'(sof), (ph == 0 && f == 0) ? 1 : 0);
    chk(scen, "eof R10", int'(eof), eof_e);
  endtask

  // enable, compare ncyc cycles, then disable and check idle
  task automatic run_span(string scen, int ncyc);
    decode_cfg();
    @(negedge clk) enable = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      check_cycle(scen, k);
    end
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check_idle(scen);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; enable = 1'b0;
    inv_hs = 1'b1; inv_vs = 1'b1; inv_pc = 1'b1; edge_en = 1'b0; edge_rise = 1'b0;
    set_geom(4, 1, 2, 0, 0, 0, 1, 1, 1);
    repeat (3) @(negedge clk);
    check_idle("R12 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R12 released");
  endtask

  task automatic test_base();
    inv_hs = 0; inv_vs = 0; inv_pc = 0; edge_en = 0; edge_rise = 0;
    set_geom(4, 1, 2, 0, 0, 0, 1, 1, 1);          // 22 px x 5 lines
    run_span("R5 base", 2 * 4 * 22 * 5 + 20);
  endtask

  task automatic test_inverted();
    inv_hs = 1; inv_vs = 1; inv_pc = 1;
    set_geom(5, 2, 0, 1, 3, 1, 2, 2, 0);          // odd divisor, no vertical front porch
    run_span("R7 inverted", 5 * 40 * 7 + 30);
    inv_hs = 0; inv_vs = 0; inv_pc = 0;
  endtask

  task automatic test_wide();
    set_geom(2, 64, 256, 64, 261, 0, 0, 0, 0);    // every horizontal high part set
    run_span("R3 wide", 2 * 1624 * 2 + 40);
  endtask

  task automatic test_tall();
    set_geom(2, 0, 0, 0, 0, 3, 0, 1027, 2);       // line count high bit set, vback zero
    run_span("R4 tall", 2 * 19 * 1034 + 40);
  endtask

  task automatic test_edges();
    set_geom(4, 1, 2, 0, 0, 0, 1, 1, 1);
    edge_en = 1; edge_rise = 1;
    run_span("R8 rise", 4 * 110 + 20);
    edge_en = 1; edge_rise = 0;
    run_span("R8 fall", 4 * 110 + 20);
    edge_en = 0; edge_rise = 1;
    run_span("R8 off", 4 * 110 + 20);
    edge_en = 0; edge_rise = 0;
  endtask

  task automatic test_clamp();
    set_geom(1, 1, 2, 0, 0, 0, 1, 1, 1);
    run_span("R2 div1", 2 * 110 + 10);
    set_geom(0, 1, 2, 0, 0, 0, 1, 1, 1);
    run_span("R2 div0", 2 * 110 + 10);
  endtask

  task automatic test_restart();
    set_geom(4, 1, 2, 0, 0, 0, 1, 1, 1);
    decode_cfg();
    @(negedge clk) enable = 1'b1;
    for (int k = 0; k < 4 * 30; k++) begin   // last sample is the final cycle of a pixel
      @(negedge clk);
      check_cycle("R11 pre", k);
    end
    enable = 1'b0;                            // drop while a pixel advance is due
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_idle("R11 drop");
    end
    run_span("R11 restart", 4 * 110 + 20);
  endtask

  initial begin
    test_reset();
    test_base();
    test_inverted();
    test_wide();
    test_tall();
    test_edges();
    test_clamp();
    test_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule